// File: doc/BRIEF.md
# Buck Switching Cycle Sequencer

This block decides, clock by clock, when the power switch of a peak-current-mode buck stage is driven. An on period ends when the sampled current-limit comparator reports that the sense voltage has reached its limit. The comparator flag is not trusted during a short blanking window that follows every turn-on. An on period also ends, whatever the comparator reports, when a maximum on time runs out.

An off period ends only when two conditions have both been met. The first is a valley event: it fires a fixed delay after the zero-cross flag is first seen. The second is the expiry of an off-timer, whose length comes from the feedback path and is clamped from below. When the valley event arrives last, the stage runs quasi-resonant. When the timer arrives last, it runs in discontinuous mode. The choice between the two follows from whichever arrives later, with no mode input. If no zero cross is ever seen, for example with a shorted load, a ceiling on the off time still restarts the switch.

A soft-start term sets a floor under the timer. It begins at the off-time ceiling and is reduced by a fixed step at the end of every off period until it reaches zero. A synchronous disable input stops switching, parks the sequencer and re-arms soft start. A mode output reports which path closed the last off period. All time constants are counts of a 10 MHz clock: 4 cycles of blanking, 500 cycles of maximum on time, 5 cycles of valley delay, 13000 cycles of off-time ceiling and 13 cycles of off-time floor.

Top module: `buck_cycle_seq`

## Requirements
- R1: While reset is high, `gate_o` and `mode_qr_o` are 0. The first on period begins on the first clock edge after reset is released, so `gate_o` is high in the first cycle after release.
- R2: During the first BLANK_CYC cycles of an on period, `lim_i` has no effect. If `lim_i` is held high from turn-on, the on period lasts exactly BLANK_CYC+1 cycles.
- R3: When `lim_i` is first high in on-cycle k (counted from 0, with k >= BLANK_CYC), the on period lasts exactly k+1 cycles.
- R4: With no limit event, the on period lasts exactly TON_MAX_CYC cycles. No on period is ever longer.
- R5: When `zcd_i` is first high in off-cycle z (counted from 0), the valley event allows turn-on after an off period of z+QR_DLY_CYC+2 cycles.
- R6: The off period lasts max(timer length, valley length), limited to TOFF_MAX_CYC. The timer length is max(clamped feedback value, soft-start term).
- R7: `fb_toff_i` values below TOFF_MIN_CYC act as TOFF_MIN_CYC. No off period that follows an on period is shorter than TOFF_MIN_CYC cycles.
- R8: If no zero cross is seen, the off period lasts exactly TOFF_MAX_CYC cycles. No off period is ever longer.
- R9: The soft-start term is TOFF_MAX_CYC after reset or disable. It drops by SS_STEP_CYC, saturating at 0, at the end of each off period. It takes part in the timer length only while `ss_en_i` is 1.
- R10: At each turn-on, `mode_qr_o` becomes 1 if the valley event was the later condition (valley length greater than timer length and within the ceiling), and 0 otherwise. It changes at no other time except when disable forces it to 0.
- R11: A high `dis_i` at a clock edge drives `gate_o` low in the next cycle and clears `mode_qr_o`. After release, an on period starts on the next edge, with soft start re-armed.
- R12: `zcd_i` during an on period has no effect on the following off period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, 10 MHz nominal |
| rst_i | input | 1 | Synchronous active-high reset |
| dis_i | input | 1 | Synchronous active-high disable |
| lim_i | input | 1 | Sampled flag: sense voltage at or above current limit |
| zcd_i | input | 1 | Sampled flag: inductor current zero cross seen |
| fb_toff_i | input | CNT_W | Feedback off-time request in clock cycles, sampled at turn-off |
| ss_en_i | input | 1 | Soft-start term enable |
| gate_o | output | 1 | Gate drive request |
| mode_qr_o | output | 1 | 1: last off period ended by valley path; 0: by timer path |

## Verification
A wrong count in the on-phase counter appears at `gate_o` as an on period that is one or more cycles too long or too short. This is visible at the first turn-off after the fault. A wrong valley delay or off-time target shows up as a wrong off length in the same switching period. A soft-start register that decays wrongly changes off periods only while it exceeds the feedback value, so the decay is checked across consecutive periods right after reset and again after a disable. A mode flag that is latched at the wrong time or from the wrong condition shows at `mode_qr_o` on the first turn-on that ends a quasi-resonant period.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
package bcs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ON   = 2'd1,
        ST_OFF  = 2'd2
    } seq_state_e;

    // events produced by the phase timers and consumed by the state machine
    typedef struct packed {
        logic on_end;    // on period must finish this cycle
        logic tmr_done;  // off-timer length reached
        logic tmr_seen;  // off-timer was already done in an earlier cycle
        logic tmr_max;   // off-time ceiling reached
        logic qr_evt;    // delayed zero-cross (valley) event present
    } seq_evt_t;

    function automatic int unsigned sat_sub(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : 0;
    endfunction

    function automatic int unsigned clamp_lo(input int unsigned v, input int unsigned lo);
        return (v < lo) ? lo : v;
    endfunction

endpackage

// File: rtl/bcs_on_timer.sv
`timescale 1ns/1ps
module bcs_on_timer #(
    parameter int unsigned BLANK_CYC   = 4,
    parameter int unsigned TON_MAX_CYC = 500
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic on_act_i,
    input  logic lim_i,
    output logic on_end_o
);
    localparam int unsigned OW = $clog2(TON_MAX_CYC + 1);
    localparam logic [OW-1:0] LAST_V = OW'(TON_MAX_CYC - 1);

    logic [OW-1:0] on_cnt_q;
    logic          blank_w;

    always_ff @(posedge clk_i) begin
        if (rst_i || !on_act_i) begin
            on_cnt_q <= '0;
        end else if (on_cnt_q != LAST_V) begin
            on_cnt_q <= on_cnt_q + 1'b1;
        end
    end

    if (BLANK_CYC == 0) begin : g_noblank
        assign blank_w = 1'b0;
    end else begin : g_blank
        localparam logic [OW-1:0] BLANK_V = OW'(BLANK_CYC);
        assign blank_w = (on_cnt_q < BLANK_V);
    end

    assign on_end_o = on_act_i && ((lim_i && !blank_w) || (on_cnt_q == LAST_V));

endmodule

// File: rtl/bcs_qr_delay.sv
`timescale 1ns/1ps
module bcs_qr_delay #(
    parameter int unsigned QR_DLY_CYC = 5
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic arm_i,
    input  logic zcd_i,
    output logic qr_evt_o
);
    logic seen_q;

    // zero cross is only honoured while the off phase is armed
    always_ff @(posedge clk_i) begin
        if (rst_i || !arm_i) begin
            seen_q <= 1'b0;
        end else if (zcd_i) begin
            seen_q <= 1'b1;
        end
    end

    if (QR_DLY_CYC == 0) begin : g_nodly
        assign qr_evt_o = seen_q;
    end else begin : g_dly
        localparam int unsigned DW = $clog2(QR_DLY_CYC + 1);
        localparam logic [DW-1:0] DLY_V = DW'(QR_DLY_CYC);
        logic [DW-1:0] dly_q;

        always_ff @(posedge clk_i) begin
            if (rst_i || !arm_i || !seen_q) begin
                dly_q <= '0;
            end else if (dly_q != DLY_V) begin
                dly_q <= dly_q + 1'b1;
            end
        end

        assign qr_evt_o = seen_q && (dly_q == DLY_V);
    end

endmodule

// File: rtl/bcs_off_timer.sv
`timescale 1ns/1ps
module bcs_off_timer import bcs_pkg::*; #(
    parameter int unsigned TOFF_MAX_CYC = 13000,
    parameter int unsigned TOFF_MIN_CYC = 13,
    parameter int unsigned CNT_W        = 14
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] fb_i,
    input  logic [CNT_W-1:0] ss_i,
    output logic             tmr_done_o,
    output logic             tmr_seen_o,
    output logic             tmr_max_o
);
    localparam logic [CNT_W-1:0] MAX_V = CNT_W'(TOFF_MAX_CYC);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] tgt_q;
    logic [CNT_W-1:0] tgt_d;
    logic [CNT_W-1:0] fb_cl;
    logic             seen_q;
    logic [CNT_W:0]   elapsed;

    always_comb begin
        fb_cl = CNT_W'(clamp_lo(32'(fb_i), TOFF_MIN_CYC));
        tgt_d = (ss_i > fb_cl) ? ss_i : fb_cl;
        if (tgt_d > MAX_V) begin
            tgt_d = MAX_V;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q  <= '0;
            tgt_q  <= MAX_V;
            seen_q <= 1'b0;
        end else if (load_i) begin
            cnt_q  <= '0;
            tgt_q  <= tgt_d;
            seen_q <= 1'b0;
        end else if (run_i) begin
            if (cnt_q != MAX_V) begin
                cnt_q <= cnt_q + 1'b1;
            end
            seen_q <= tmr_done_o;
        end
    end

    assign elapsed    = {1'b0, cnt_q} + 1'b1;
    assign tmr_done_o = (elapsed >= {1'b0, tgt_q});
    assign tmr_max_o  = (elapsed >= {1'b0, MAX_V});
    assign tmr_seen_o = seen_q;

endmodule

// File: rtl/bcs_softstart.sv
`timescale 1ns/1ps
module bcs_softstart import bcs_pkg::*; #(
    parameter int unsigned TOFF_MAX_CYC = 13000,
    parameter int unsigned SS_STEP_CYC  = 650,
    parameter int unsigned CNT_W        = 14
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             restart_i,
    input  logic             step_i,
    input  logic             en_i,
    output logic [CNT_W-1:0] ss_o
);
    logic [CNT_W-1:0] ss_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || restart_i) begin
            ss_q <= CNT_W'(TOFF_MAX_CYC);
        end else if (step_i) begin
            ss_q <= CNT_W'(sat_sub(32'(ss_q), SS_STEP_CYC));
        end
    end

    assign ss_o = en_i ? ss_q : '0;

endmodule

// File: rtl/buck_cycle_seq.sv
`timescale 1ns/1ps
module buck_cycle_seq import bcs_pkg::*; #(
    parameter int unsigned BLANK_CYC    = 4,
    parameter int unsigned TON_MAX_CYC  = 500,
    parameter int unsigned QR_DLY_CYC   = 5,
    parameter int unsigned TOFF_MAX_CYC = 13000,
    parameter int unsigned TOFF_MIN_CYC = 13,
    parameter int unsigned SS_STEP_CYC  = 650,
    parameter int unsigned CNT_W        = $clog2(TOFF_MAX_CYC + 1)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             dis_i,
    input  logic             lim_i,
    input  logic             zcd_i,
    input  logic [CNT_W-1:0] fb_toff_i,
    input  logic             ss_en_i,
    output logic             gate_o,
    output logic             mode_qr_o
);
    seq_state_e       st_q;
    seq_state_e       st_d;
    seq_evt_t         ev;
    logic [CNT_W-1:0] ss_w;
    logic             mode_q;
    logic             on_act;
    logic             off_act;
    logic             off_load;
    logic             off_end;

    assign on_act   = (st_q == ST_ON);
    assign off_act  = (st_q == ST_OFF);
    assign off_load = on_act && ev.on_end && !dis_i;
    assign off_end  = off_act && !dis_i && ((ev.qr_evt && ev.tmr_done) || ev.tmr_max);

    bcs_on_timer #(
        .BLANK_CYC   (BLANK_CYC),
        .TON_MAX_CYC (TON_MAX_CYC)
    ) u_on (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .on_act_i (on_act),
        .lim_i    (lim_i),
        .on_end_o (ev.on_end)
    );

    bcs_qr_delay #(
        .QR_DLY_CYC (QR_DLY_CYC)
    ) u_qr (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .arm_i    (off_act),
        .zcd_i    (zcd_i),
        .qr_evt_o (ev.qr_evt)
    );

    bcs_softstart #(
        .TOFF_MAX_CYC (TOFF_MAX_CYC),
        .SS_STEP_CYC  (SS_STEP_CYC),
        .CNT_W        (CNT_W)
    ) u_ss (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .restart_i (dis_i),
        .step_i    (off_end),
        .en_i      (ss_en_i),
        .ss_o      (ss_w)
    );

    bcs_off_timer #(
        .TOFF_MAX_CYC (TOFF_MAX_CYC),
        .TOFF_MIN_CYC (TOFF_MIN_CYC),
        .CNT_W        (CNT_W)
    ) u_off (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (off_load),
        .run_i      (off_act),
        .fb_i       (fb_toff_i),
        .ss_i       (ss_w),
        .tmr_done_o (ev.tmr_done),
        .tmr_seen_o (ev.tmr_seen),
        .tmr_max_o  (ev.tmr_max)
    );

    always_comb begin
        st_d = st_q;
        if (dis_i) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: st_d = ST_ON;
                ST_ON:   if (ev.on_end) st_d = ST_OFF;
                ST_OFF:  if (off_end)   st_d = ST_ON;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q   <= ST_IDLE;
            mode_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (dis_i) begin
                mode_q <= 1'b0;
            end else if (off_end) begin
                // valley path wins only if the timer had already finished
                mode_q <= ev.qr_evt && ev.tmr_seen;
            end
        end
    end

    assign gate_o    = on_act;
    assign mode_qr_o = mode_q;

endmodule

// File: rtl/bcs_checks.sv
`timescale 1ns/1ps
module bcs_checks #(
    parameter int unsigned BLANK_CYC    = 4,
    parameter int unsigned TON_MAX_CYC  = 500,
    parameter int unsigned TOFF_MAX_CYC = 13000,
    parameter int unsigned TOFF_MIN_CYC = 13
) (
    input logic clk_i,
    input logic rst_i,
    input logic dis_i,
    input logic gate_o,
    input logic mode_qr_o
);
    int unsigned on_len;
    int unsigned off_len;
    logic        from_fall;

    always_ff @(posedge clk_i) begin
        if (rst_i || !gate_o) on_len <= 0;
        else                  on_len <= on_len + 1;
        if (rst_i || gate_o || dis_i) off_len <= 0;
        else                          off_len <= off_len + 1;
        if (rst_i || dis_i) from_fall <= 1'b0;
        else if (gate_o)    from_fall <= 1'b1;
    end

    a_r1_reset_quiet: assert property (@(posedge clk_i)
        rst_i |=> (!gate_o && !mode_qr_o));

    a_r2_blank_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (gate_o && !dis_i && on_len < BLANK_CYC) |=> gate_o);

    a_r4_on_ceiling: assert property (@(posedge clk_i) disable iff (rst_i)
        gate_o |-> (on_len < TON_MAX_CYC));

    a_r7_off_floor: assert property (@(posedge clk_i) disable iff (rst_i)
        (!gate_o && !dis_i && from_fall && off_len < TOFF_MIN_CYC - 1) |=> !gate_o);

    a_r8_off_ceiling: assert property (@(posedge clk_i) disable iff (rst_i)
        !gate_o |-> (off_len < TOFF_MAX_CYC));

    a_r10_mode_at_turn_on: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(dis_i) && !$rose(gate_o)) |-> $stable(mode_qr_o));

    a_r11_disable_drop: assert property (@(posedge clk_i) disable iff (rst_i)
        dis_i |=> (!gate_o && !mode_qr_o));

endmodule

bind buck_cycle_seq bcs_checks #(
    .BLANK_CYC    (BLANK_CYC),
    .TON_MAX_CYC  (TON_MAX_CYC),
    .TOFF_MAX_CYC (TOFF_MAX_CYC),
    .TOFF_MIN_CYC (TOFF_MIN_CYC)
) u_bcs_checks (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .dis_i     (dis_i),
    .gate_o    (gate_o),
    .mode_qr_o (mode_qr_o)
);

// File: tb/test_buck_cycle_seq.sv
`timescale 1ns/1ps
module test_buck_cycle_seq;
    localparam int BLK = 4;
    localparam int TON = 40;
    localparam int QRD = 5;
    localparam int TMX = 200;
    localparam int TMN = 12;
    localparam int SSS = 60;
    localparam int CW  = 8;

    logic          clk   = 1'b0;
    logic          rst   = 1'b1;
    logic          dis   = 1'b0;
    logic          lim   = 1'b0;
    logic          zcd   = 1'b0;
    logic          ss_en = 1'b0;
    logic [CW-1:0] fb    = '0;
    logic          gate;
    logic          mode;

    int n_vec = 0;
    int n_bad = 0;
    int ss_model = TMX;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    buck_cycle_seq #(
        .BLANK_CYC    (BLK),
        .TON_MAX_CYC  (TON),
        .QR_DLY_CYC   (QRD),
        .TOFF_MAX_CYC (TMX),
        .TOFF_MIN_CYC (TMN),
        .SS_STEP_CYC  (SSS),
        .CNT_W        (CW)
    ) i_buck_cycle_seq (
        .clk_i     (clk),
        .rst_i     (rst),
        .dis_i     (dis),
        .lim_i     (lim),
        .zcd_i     (zcd),
        .fb_toff_i (fb),
        .ss_en_i   (ss_en),
        .gate_o    (gate),
        .mode_qr_o (mode)
    );

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // Entered at a falling edge where gate has just been seen high.
    // zcd_at < 0 means no zero cross during the off period.
    task automatic run_cycle(input int lim_at, input int zcd_at, input int fbv, input bit zcd_on);
        int ton;
        int toff;
        int ton_e;
        int nt;
        int nq;
        int toff_e;
        int mode_e;
        string tt;
        string tf;
        ton  = 0;
        toff = 0;
        fb   = CW'(fbv);
        while (gate === 1'b1 && ton < 1000) begin
            lim = (ton >= lim_at);
            zcd = zcd_on;
            @(negedge clk);
            ton++;
        end
        lim = 1'b0;
        zcd = 1'b0;
        while (gate === 1'b0 && toff < 1000) begin
            zcd = (zcd_at >= 0 && toff >= zcd_at);
            @(negedge clk);
            toff++;
        end
        zcd = 1'b0;

        ton_e = (lim_at >= TON) ? TON : imin(imax(lim_at, BLK) + 1, TON);
        if (lim_at >= TON)     tt = "R4 on ceiling";
        else if (lim_at < BLK) tt = "R2 blanking";
        else                   tt = "R3 limit end";
        check(tt, ton, ton_e);

        nt = imin(imax(imax(fbv, TMN), ss_en ? ss_model : 0), TMX);
        nq = (zcd_at < 0) ? 100000 : zcd_at + QRD + 2;
        toff_e = imin(TMX, imax(nt, nq));
        mode_e = (zcd_at >= 0 && nq > nt && nq <= TMX) ? 1 : 0;
        if (zcd_on)           tf = "R12 zcd during on";
        else if (zcd_at < 0)  tf = "R8 no zero cross";
        else if (fbv < TMN)   tf = "R7 feedback floor";
        else if (nq > nt)     tf = "R5 valley delay";
        else                  tf = "R6 later of two";
        check(tf, toff, toff_e);
        check("R10 mode", int'(mode), mode_e);
        ss_model = imax(0, ss_model - SSS);
    endtask

    initial begin
        #(150000 * 5);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int lims[9] = '{0, 2, 3, 4, 5, 10, 39, 40, 50};
        int zcds[8] = '{-1, 0, 3, 8, 20, 60, 193, 195};
        int fbs[7]  = '{0, 5, 12, 13, 30, 100, 250};

        repeat (5) @(negedge clk);
        check("R1 reset gate", int'(gate), 0);
        check("R1 reset mode", int'(mode), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 first turn-on", int'(gate), 1);

        // R9: soft start decays 200,140,80,20,0 against fb = 20
        ss_en = 1'b1;
        for (int i = 0; i < 5; i++) begin
            check("R9 soft-start term", ss_model, imax(0, TMX - i * SSS));
            run_cycle(10, 0, 20, 1'b0);
        end

        // sweep with the soft-start term excluded
        ss_en = 1'b0;
        foreach (lims[a]) begin
            foreach (zcds[b]) begin
                foreach (fbs[c]) begin
                    run_cycle(lims[a], zcds[b], fbs[c], 1'b0);
                end
            end
        end

        // R9: term has decayed to zero, enabling it changes nothing
        ss_en = 1'b1;
        run_cycle(10, -1, 30, 1'b0);
        run_cycle(10, 0, 30, 1'b0);
        ss_en = 1'b0;

        // R12: zero cross during the on period is ignored
        run_cycle(10, -1, 30, 1'b1);
        run_cycle(10, 3, 30, 1'b1);

        // R11: disable during an on period, after a valley-ended period
        run_cycle(10, 40, 12, 1'b0);
        check("R10 mode before disable", int'(mode), 1);
        dis = 1'b1;
        @(negedge clk);
        check("R11 gate drop", int'(gate), 0);
        check("R11 mode clear", int'(mode), 0);
        begin
            int highs;
            highs = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                highs += int'(gate);
            end
            check("R11 held idle", highs, 0);
        end
        dis = 1'b0;
        @(negedge clk);
        check("R11 restart", int'(gate), 1);
        ss_model = TMX;
        ss_en = 1'b1;
        run_cycle(10, 0, 20, 1'b0);
        run_cycle(10, 0, 20, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule